// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Bus Port

This block is a bus master for external SRAM and simple peripherals that share a single 16-bit address/data bus. It converts one internal request into a fixed sequence of bus phases. One or two address-latch phases, marked by the `bus_ale` strobe, come first. A single read or write strobe phase follows. A closing phase then returns read data and a completion pulse. Each bus cycle has a fixed length: no wait states are inserted.

Two internal sources can start a transfer: the core register path and a DMA engine. Each source gives a direction, a device-width mode, an address and write data. When both sources ask in the same accepting cycle, the core wins. The completion pulse goes only to the source that was served.

In byte mode the port reaches a 24-bit address space. It first puts the top 8 address bits on the bus in their own latch phase, then the low 16 bits. In word mode there is one latch phase carrying 16 address bits. The upper request bits are not used in word mode.

The state machine has five states:
- `ST_IDLE`: waiting for a request.
- `ST_ADR_HI`: upper address latch phase, byte mode only.
- `ST_ADR_LO`: low address latch phase.
- `ST_XFER`: read or write strobe phase.
- `ST_FIN`: closing phase, with done asserted.

The transitions are:
- IDLE→ADR_HI when a byte-mode request is accepted.
- IDLE→ADR_LO when a word-mode request is accepted.
- ADR_HI→ADR_LO, ADR_LO→XFER and XFER→FIN, each unconditionally.
- FIN→ADR_HI or FIN→ADR_LO when a new request is accepted in the done cycle.
- FIN→IDLE otherwise.

A word-mode transfer therefore occupies three clocks, and a byte-mode transfer occupies four.

Top module: `mux_bus_port`

## Requirements
- R1: After reset, `bus_ale`, `bus_rd`, `bus_wr`, `ad_oe`, `busy`, `core_done` and `dma_done` are all 0.
- R2: In word mode (`*_byte`=0), the first cycle after acceptance has `bus_ale`=1 and `ad_oe`=1, with `ad_o` equal to address bits [15:0]. The strobe cycle follows, then the done cycle.
- R3: In byte mode (`*_byte`=1), there are two latch cycles after acceptance. In the first, `ad_o` = {8'h00, addr[23:16]}. In the second, `ad_o` = addr[15:0]. `bus_ale`=1 and `ad_oe`=1 in both. The strobe cycle follows, then the done cycle.
- R4: A write (`*_wr`=1) has a strobe cycle with `bus_wr`=1 and `ad_oe`=1. During it, `ad_o` equals the write data in word mode, or {8'h00, wdata[7:0]} in byte mode.
- R5: A read (`*_wr`=0) has a strobe cycle with `bus_rd`=1 and `ad_oe`=0. `ad_i` is sampled at the clock edge that ends that cycle. `rdata` shows the sampled word in word mode, or {8'h00, ad_i[7:0]} in byte mode, from the done cycle on.
- R6: The strobes are active high, and at most one of `bus_ale`, `bus_rd` and `bus_wr` is 1 in any cycle.
- R7: `busy` is 1 from the cycle after acceptance up to the done cycle. In the done cycle the served source's done is 1 for one cycle and `busy` is 0. A request present in the done cycle is accepted. A request held high therefore completes every 3 cycles in word mode and every 4 cycles in byte mode.
- R8: A request that is raised and removed while `busy` is 1 has no effect. No extra latch phase and no done pulse follow it.
- R9: When both sources request in the same accepting cycle, the core is served first. Only `core_done` pulses for that transfer. A DMA request still present is then served next.
- R10: A write leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core register-path request |
| core_wr | input | 1 | Core direction: 1 write, 0 read |
| core_byte | input | 1 | Core mode: 1 byte device, 0 word device |
| core_addr | input | 24 | Core address |
| core_wdata | input | 16 | Core write data |
| core_done | output | 1 | Core transfer complete pulse |
| dma_req | input | 1 | DMA request |
| dma_wr | input | 1 | DMA direction |
| dma_byte | input | 1 | DMA device mode |
| dma_addr | input | 24 | DMA address |
| dma_wdata | input | 16 | DMA write data |
| dma_done | output | 1 | DMA transfer complete pulse |
| rdata | output | 16 | Last read data |
| busy | output | 1 | Transfer in progress, requests not accepted |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| ad_o | output | 16 | Address/data bus output value |
| ad_oe | output | 1 | Bus output enable |
| ad_i | input | 16 | Address/data bus input value |

## Verification
Completing one transfer and accepting the next can fall in the same cycle. The done cycle of one transfer is also the cycle that accepts a following request, so a stale address or direction could leak into the new latch phase. The bench provokes this in two ways. It holds a request high across several transfers in each mode and counts done pulses over a fixed window. It also has both sources request together, so the DMA transfer starts in the core's done cycle. The check is that the first latch phase after the core's done carries the DMA address, and that each done pulse goes only to its own source.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADR_HI = 3'd1,
        ST_ADR_LO = 3'd2,
        ST_XFER   = 3'd3,
        ST_FIN    = 3'd4
    } mbp_state_e;

    typedef enum logic {
        SRC_CORE = 1'b0,
        SRC_DMA  = 1'b1
    } mbp_src_e;

endpackage

// File: rtl/mbp_arb.sv
module mbp_arb
    import mbp_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          ready,
    input  logic          core_req,
    input  logic          core_wr,
    input  logic          core_byte,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    input  logic          dma_req,
    input  logic          dma_wr,
    input  logic          dma_byte,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_wdata,
    output logic          go,
    output mbp_src_e      sel_src,
    output logic          sel_wr,
    output logic          sel_byte,
    output logic [AW-1:0] sel_addr,
    output logic [DW-1:0] sel_wdata,
    input  logic          done,
    input  mbp_src_e      done_src,
    output logic          core_done,
    output logic          dma_done
);

    // fixed priority: the core path wins over DMA
    always_comb begin
        go = ready && (core_req || dma_req);
        if (core_req) begin
            sel_src   = SRC_CORE;
            sel_wr    = core_wr;
            sel_byte  = core_byte;
            sel_addr  = core_addr;
            sel_wdata = core_wdata;
        end else begin
            sel_src   = SRC_DMA;
            sel_wr    = dma_wr;
            sel_byte  = dma_byte;
            sel_addr  = dma_addr;
            sel_wdata = dma_wdata;
        end
    end

    always_comb begin
        core_done = done && (done_src == SRC_CORE);
        dma_done  = done && (done_src == SRC_DMA);
    end

endmodule

// File: rtl/mbp_fsm.sv
module mbp_fsm
    import mbp_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  mbp_src_e      sel_src,
    input  logic          sel_wr,
    input  logic          sel_byte,
    input  logic [AW-1:0] sel_addr,
    input  logic [DW-1:0] sel_wdata,
    output logic          ready,
    output logic          ale,
    output logic          rd,
    output logic          wr,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic          done,
    output mbp_src_e      done_src
);

    localparam int HW = AW - DW;   // upper address bits, byte mode
    localparam int BW = DW / 2;    // byte lane width

    mbp_state_e state, nxt;

    logic          lat_wr, lat_byte;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    mbp_src_e      lat_src;

    logic          eff_wr, eff_byte;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] eff_wdata;

    assign ready = (state == ST_IDLE) || (state == ST_FIN);

    // fields of the transfer that owns the next state
    always_comb begin
        if (go) begin
            eff_wr    = sel_wr;
            eff_byte  = sel_byte;
            eff_addr  = sel_addr;
            eff_wdata = sel_wdata;
        end else begin
            eff_wr    = lat_wr;
            eff_byte  = lat_byte;
            eff_addr  = lat_addr;
            eff_wdata = lat_wdata;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = go ? (sel_byte ? ST_ADR_HI : ST_ADR_LO) : ST_IDLE;
            ST_ADR_HI: nxt = ST_ADR_LO;
            ST_ADR_LO: nxt = ST_XFER;
            ST_XFER:   nxt = ST_FIN;
            ST_FIN:    nxt = go ? (sel_byte ? ST_ADR_HI : ST_ADR_LO) : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_wr    <= 1'b0;
            lat_byte  <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_src   <= SRC_CORE;
        end else begin
            state <= nxt;
            if (go) begin
                lat_wr    <= sel_wr;
                lat_byte  <= sel_byte;
                lat_addr  <= sel_addr;
                lat_wdata <= sel_wdata;
                lat_src   <= sel_src;
            end
        end
    end

    // registered outputs, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale      <= 1'b0;
            rd       <= 1'b0;
            wr       <= 1'b0;
            ad_o     <= '0;
            ad_oe    <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            done_src <= SRC_CORE;
            rdata    <= '0;
        end else begin
            ale   <= (nxt == ST_ADR_HI) || (nxt == ST_ADR_LO);
            rd    <= (nxt == ST_XFER) && !eff_wr;
            wr    <= (nxt == ST_XFER) && eff_wr;
            ad_oe <= (nxt == ST_ADR_HI) || (nxt == ST_ADR_LO) ||
                     ((nxt == ST_XFER) && eff_wr);
            busy  <= (nxt != ST_IDLE) && (nxt != ST_FIN);
            done  <= (nxt == ST_FIN);
            if (nxt == ST_FIN)
                done_src <= lat_src;
            unique case (nxt)
                ST_ADR_HI: ad_o <= {{(DW-HW){1'b0}}, eff_addr[AW-1:DW]};
                ST_ADR_LO: ad_o <= eff_addr[DW-1:0];
                ST_XFER:   ad_o <= eff_byte ? {{(DW-BW){1'b0}}, eff_wdata[BW-1:0]}
                                            : eff_wdata;
                default:   ad_o <= '0;
            endcase
            // sample on the edge where the read strobe falls
            if (state == ST_XFER && !lat_wr)
                rdata <= lat_byte ? {{(DW-BW){1'b0}}, ad_i[BW-1:0]} : ad_i;
        end
    end

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ale, rd, wr}));

    // R5
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> !ad_oe);

    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> ad_oe);

    // R7
    done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    strobe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd || wr) |=> done);

    // R2
    lo_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADR_LO) |=> (rd || wr));

    // R3
    hi_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADR_HI) |=> (state == ST_ADR_LO && ale && ad_oe));

endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port
    import mbp_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic          core_wr,
    input  logic          core_byte,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_done,
    input  logic          dma_req,
    input  logic          dma_wr,
    input  logic          dma_byte,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_wdata,
    output logic          dma_done,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_i
);

    logic          go, ready, done;
    mbp_src_e      sel_src, done_src;
    logic          sel_wr, sel_byte;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;

    mbp_arb #(.AW(AW), .DW(DW)) i_arb (
        .ready      (ready),
        .core_req   (core_req),
        .core_wr    (core_wr),
        .core_byte  (core_byte),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .dma_req    (dma_req),
        .dma_wr     (dma_wr),
        .dma_byte   (dma_byte),
        .dma_addr   (dma_addr),
        .dma_wdata  (dma_wdata),
        .go         (go),
        .sel_src    (sel_src),
        .sel_wr     (sel_wr),
        .sel_byte   (sel_byte),
        .sel_addr   (sel_addr),
        .sel_wdata  (sel_wdata),
        .done       (done),
        .done_src   (done_src),
        .core_done  (core_done),
        .dma_done   (dma_done)
    );

    mbp_fsm #(.AW(AW), .DW(DW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .sel_src   (sel_src),
        .sel_wr    (sel_wr),
        .sel_byte  (sel_byte),
        .sel_addr  (sel_addr),
        .sel_wdata (sel_wdata),
        .ready     (ready),
        .ale       (bus_ale),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe),
        .ad_i      (ad_i),
        .rdata     (rdata),
        .busy      (busy),
        .done      (done),
        .done_src  (done_src)
    );

    // R9
    done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_done && dma_done));

    // R9
    core_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && dma_req && !busy && !bus_rd && !bus_wr) |=>
            (bus_ale && ad_oe));

endmodule

// File: tb/test_mux_bus_port.sv
module test_mux_bus_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 0, core_wr = 0, core_byte = 0;
    logic [23:0] core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic        dma_req = 0, dma_wr = 0, dma_byte = 0;
    logic [23:0] dma_addr = '0;
    logic [15:0] dma_wdata = '0;
    logic [15:0] ad_i = '0;
    logic        core_done, dma_done, busy, bus_ale, bus_rd, bus_wr, ad_oe;
    logic [15:0] rdata, ad_o;

    int total = 0;
    int bad = 0;
    logic [15:0] last_rd = '0;

    always #4 clk = ~clk;   // 125 MHz

    mux_bus_port i_mux_bus_port (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_wr(core_wr), .core_byte(core_byte),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
        .dma_req(dma_req), .dma_wr(dma_wr), .dma_byte(dma_byte),
        .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_done(dma_done),
        .rdata(rdata), .busy(busy), .bus_ale(bus_ale), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lane(input bit b, input logic [15:0] v);
        return b ? {8'h00, v[7:0]} : v;
    endfunction

    function automatic logic [15:0] hi_part(input logic [23:0] a);
        return {8'h00, a[23:16]};
    endfunction

    task automatic xfer(input bit src, input bit w, input bit b,
                        input logic [23:0] a, input logic [15:0] d,
                        input logic [15:0] rv);
        @(negedge clk);
        if (src) begin
            dma_req = 1; dma_wr = w; dma_byte = b; dma_addr = a; dma_wdata = d;
        end else begin
            core_req = 1; core_wr = w; core_byte = b; core_addr = a; core_wdata = d;
        end
        @(negedge clk);
        core_req = 0; dma_req = 0;
        if (b) begin
            chk("R3 hi phase", {ad_o, bus_ale, ad_oe, busy}, {hi_part(a), 3'b111});
            @(negedge clk);
            chk("R3 lo phase", {ad_o, bus_ale, ad_oe, busy}, {a[15:0], 3'b111});
        end else begin
            chk("R2 addr phase", {ad_o, bus_ale, ad_oe, busy}, {a[15:0], 3'b111});
        end
        ad_i = rv;
        @(negedge clk);
        if (w)
            chk("R4 write phase", {ad_o, bus_ale, bus_rd, bus_wr, ad_oe},
                {lane(b, d), 4'b0011});
        else
            chk("R5 read phase", {bus_ale, bus_rd, bus_wr, ad_oe, busy}, 5'b01001);
        chk("R6 strobes", 32'($countones({bus_ale, bus_rd, bus_wr})), 32'd1);
        @(negedge clk);
        chk("R7 done cycle", {core_done, dma_done, busy, ad_oe, bus_rd, bus_wr},
            {!src, src, 4'b0000});
        if (!w) last_rd = lane(b, rv);
        chk(w ? "R10 rdata kept" : "R5 rdata", rdata, last_rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R7 act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int dn;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        // R1
        chk("R1 reset", {bus_ale, bus_rd, bus_wr, ad_oe, busy, core_done, dma_done}, 7'b0);
        rst_n = 1;
        @(negedge clk);

        // directed corners
        xfer(0, 0, 0, 24'hABCDEF, 16'h0000, 16'hBEEF);
        xfer(0, 1, 0, 24'hFF1234, 16'hA55A, 16'h0000);
        xfer(1, 0, 1, 24'hFFFFFF, 16'h0000, 16'h12FE);
        xfer(1, 1, 1, 24'h800001, 16'h7788, 16'h0000);

        // R7 held request, word mode: 3-cycle period
        @(negedge clk);
        core_req = 1; core_wr = 1; core_byte = 0; core_addr = 24'h000100;
        dn = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (core_done) dn++;
        end
        core_req = 0;
        chk("R7 word back-to-back", dn, 4);
        repeat (3) @(negedge clk);

        // R7 held request, byte mode: 4-cycle period
        core_req = 1; core_wr = 1; core_byte = 1;
        dn = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (core_done) dn++;
        end
        core_req = 0;
        chk("R7 byte back-to-back", dn, 3);
        repeat (3) @(negedge clk);

        // R8 request while busy is ignored
        core_req = 1; core_wr = 0; core_byte = 0; core_addr = 24'h001111;
        @(negedge clk);
        core_req = 0;
        dma_req = 1; dma_wr = 1; dma_byte = 0; dma_addr = 24'h002222;
        chk("R8 busy during", busy, 1);
        @(negedge clk);
        dma_req = 0;
        @(negedge clk);
        chk("R8 core done", {core_done, dma_done}, 2'b10);
        last_rd = ad_i;
        dn = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (bus_ale || dma_done || busy) dn++;
        end
        chk("R8 no effect", dn, 0);

        // R9 simultaneous requests, core first then DMA in done cycle
        core_req = 1; core_wr = 1; core_byte = 0; core_addr = 24'h00AAAA;
        dma_req = 1; dma_wr = 1; dma_byte = 0; dma_addr = 24'h005555;
        @(negedge clk);
        chk("R9 core addr first", ad_o, 16'hAAAA);
        core_req = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 core done only", {core_done, dma_done}, 2'b10);
        @(negedge clk);
        chk("R9 dma addr next", {ad_o, bus_ale}, {16'h5555, 1'b1});
        dma_req = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 dma done only", {core_done, dma_done}, 2'b01);
        @(negedge clk);

        // random mix
        for (int k = 0; k < 40; k++) begin
            xfer($urandom_range(1), $urandom_range(1), $urandom_range(1),
                 24'($urandom), 16'($urandom), 16'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule